// File: doc/BRIEF.md
# Write-Masked Configuration Register Bank

This block is a small set of 32-bit configuration registers for a camera PHY and its start-up sequencer. A simple bus presents a select, a write strobe, a byte address and 32 bits of write data each cycle. On a write, the upper 16 bits of the data are a per-bit write enable for the lower 16 bits. Software can therefore set or clear any group of fields in one write, without reading the register first.

The writable registers hold the PHY input select, the test-bus select, the lane enables and turn-disable bits of two receive PHYs, the turn-request bits, the PHY test-port pins, the IO voltage select and the clock-output drive strength. One further register is read-only and returns the PHY's 8-bit test data output.

Every stored field drives its output pin directly from the flops. Read data and the error flag are registered, and they appear one cycle after the access. The sequencer that toggles the test port and the logic that decodes the fields inside the PHY are outside this block.

Top module: `cfg_mask_regbank`

## Requirements
- R1: On a write to a mapped writable register, low bit i takes `bus_wdata[i]` only when `bus_wdata[16+i]` is 1. Every other bit keeps its value, so a write with all upper bits zero changes nothing.
- R2: Asserting `rst_n` low clears every writable field to zero at once, and the fields stay zero until the first write after reset is released.
- R3: A read of a mapped register returns the stored implemented bits in `bus_rdata[15:0]`, with zero in bits that are not implemented and zero in `bus_rdata[31:16]`. The read data appears in the cycle after the access, and `bus_rdata` is zero in cycles after non-read accesses.
- R4: Offset 0x25C: bit 1 drives `phy_in_sel`, and bit 14 drives `testbus_sel`.
- R5: Offset 0x26C is lane register A and offset 0x268 is lane register B. In each, bits 3:0 are turn-disable (`turn_dis_a`/`turn_dis_b`) and bits 15:12 are lane enable (`lane_en_a`/`lane_en_b`).
- R6: Offset 0x27C is the test port: bit 0 `tp_clr`, bit 1 `tp_clk`, bit 2 `tp_en`, bits 10:3 `tp_din`.
- R7: Offset 0x3A4: bits 3:0 drive `turn_req`.
- R8: Offset 0x380: bit 1 drives `io_v18` (1 selects 1.8 V, 0 selects 3.3 V), and bits 4:3 drive `clkout_drv`.
- R9: Offset 0x2D4 reads `phy_test_dout` in bits 7:0, sampled in the access cycle. A write to it changes no field and raises no error.
- R10: An access to any other address, including a misaligned one, reads zero and changes no field. It sets `bus_err` for exactly the cycle after that access.
- R11: A field output shows its new value in the cycle right after the clock edge that takes the write, with no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data: enables [31:16], values [15:0] |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered error for an unmapped access |
| phy_test_dout | input | 8 | PHY test data output |
| phy_in_sel | output | 1 | PHY input select |
| testbus_sel | output | 1 | Test-bus select |
| lane_en_a | output | 4 | Lane enables, PHY A |
| turn_dis_a | output | 4 | Turn-disable, PHY A |
| lane_en_b | output | 4 | Lane enables, PHY B |
| turn_dis_b | output | 4 | Turn-disable, PHY B |
| turn_req | output | 4 | Turn-request bits |
| tp_clr | output | 1 | Test-port clear |
| tp_clk | output | 1 | Test-port clock |
| tp_en | output | 1 | Test-port enable |
| tp_din | output | 8 | Test-port data in |
| io_v18 | output | 1 | IO voltage select |
| clkout_drv | output | 2 | Clock-output drive strength |

## Verification
The first pattern is a walking single-bit sweep over each register. It sets and then clears each bit with only that bit's enable raised, which separates a correct per-bit mask from a swapped, shifted or ignored enable, and exposes every field's bit position at its output pin. A long pseudo-random sequence of mixed enables and data checks the merge of old and new bits against a bench model. Writes with data but no enables check that nothing changes without an enable. The status register is read with several test-output patterns and then written, and a set of unmapped and misaligned addresses tells the error pulse and the zero read apart from a real decode.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int OFS_W  = 12;
  localparam int NREG   = 6;

  localparam int IDX_PORT  = 0;
  localparam int IDX_LANEB = 1;
  localparam int IDX_LANEA = 2;
  localparam int IDX_TPORT = 3;
  localparam int IDX_IOCFG = 4;
  localparam int IDX_TURN  = 5;

  localparam logic [OFS_W-1:0] OFS_PORT  = 12'h25C;
  localparam logic [OFS_W-1:0] OFS_LANEB = 12'h268;
  localparam logic [OFS_W-1:0] OFS_LANEA = 12'h26C;
  localparam logic [OFS_W-1:0] OFS_TPORT = 12'h27C;
  localparam logic [OFS_W-1:0] OFS_IOCFG = 12'h380;
  localparam logic [OFS_W-1:0] OFS_TURN  = 12'h3A4;
  localparam logic [OFS_W-1:0] OFS_STAT  = 12'h2D4;

  typedef logic [HALF_W-1:0] half_t;

  // Entry 0 is the rightmost element.
  localparam logic [NREG-1:0][OFS_W-1:0] REG_OFS =
    {OFS_TURN, OFS_IOCFG, OFS_TPORT, OFS_LANEA, OFS_LANEB, OFS_PORT};

  // Implemented (writable) bits of each register.
  localparam logic [NREG-1:0][HALF_W-1:0] REG_IMPL =
    {16'h000F, 16'h001A, 16'h07FF, 16'hF00F, 16'hF00F, 16'h4002};
endpackage

// File: rtl/regbank_rst_sync.sv
module regbank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   reg_hit,
  output logic              stat_hit,
  output logic              mapped
);
  for (genvar gi = 0; gi < NREG; gi++) begin : g_cmp
    assign reg_hit[gi] = (addr == ADDR_W'(REG_OFS[gi]));
  end

  assign stat_hit = (addr == ADDR_W'(OFS_STAT));
  assign mapped   = (|reg_hit) | stat_hit;
endmodule

// File: rtl/regbank_mreg.sv
module regbank_mreg
  import regbank_pkg::*;
#(
  parameter logic [HALF_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output half_t             q
);
  half_t bit_en;
  half_t q_d;

  always_comb begin
    bit_en = wr_stb ? (wdata[DATA_W-1:HALF_W] & IMPL) : '0;
    q_d    = (q & ~bit_en) | (wdata[HALF_W-1:0] & bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_stb) q <= q_d;
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
  import regbank_pkg::*;
(
  input  logic [NREG-1:0]             reg_hit,
  input  logic                        stat_hit,
  input  logic [NREG-1:0][HALF_W-1:0] reg_q,
  input  half_t                       stat_val,
  output half_t                       rd_half
);
  always_comb begin
    rd_half = stat_hit ? stat_val : '0;
    for (int i = 0; i < NREG; i++) begin
      if (reg_hit[i]) rd_half = rd_half | reg_q[i];
    end
  end
endmodule

// File: rtl/cfg_mask_regbank.sv
module cfg_mask_regbank
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [7:0]        phy_test_dout,
  output logic              phy_in_sel,
  output logic              testbus_sel,
  output logic [3:0]        lane_en_a,
  output logic [3:0]        turn_dis_a,
  output logic [3:0]        lane_en_b,
  output logic [3:0]        turn_dis_b,
  output logic [3:0]        turn_req,
  output logic              tp_clr,
  output logic              tp_clk,
  output logic              tp_en,
  output logic [7:0]        tp_din,
  output logic              io_v18,
  output logic [1:0]        clkout_drv
);
  logic                        rst_sync_n;
  logic [NREG-1:0]             reg_hit;
  logic                        stat_hit;
  logic                        mapped;
  logic [NREG-1:0][HALF_W-1:0] reg_q;
  half_t                       rd_half;
  half_t                       stat_val;
  logic                        wr_any;
  logic                        rd_any;
  logic [DATA_W-1:0]           rdata_d;
  logic                        err_d;

  regbank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .reg_hit  (reg_hit),
    .stat_hit (stat_hit),
    .mapped   (mapped)
  );

  assign wr_any = bus_sel & bus_we;
  assign rd_any = bus_sel & ~bus_we;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    regbank_mreg #(.IMPL(REG_IMPL[gi])) u_mreg (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_stb (wr_any & reg_hit[gi]),
      .wdata  (bus_wdata),
      .q      (reg_q[gi])
    );
  end

  assign stat_val = {{(HALF_W-8){1'b0}}, phy_test_dout};

  regbank_rdmux u_mux (
    .reg_hit  (reg_hit),
    .stat_hit (stat_hit),
    .reg_q    (reg_q),
    .stat_val (stat_val),
    .rd_half  (rd_half)
  );

  always_comb begin
    rdata_d = (rd_any && mapped) ? {{HALF_W{1'b0}}, rd_half} : '0;
    err_d   = bus_sel & ~mapped;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= err_d;
    end
  end

  assign phy_in_sel  = reg_q[IDX_PORT][1];
  assign testbus_sel = reg_q[IDX_PORT][14];
  assign turn_dis_b  = reg_q[IDX_LANEB][3:0];
  assign lane_en_b   = reg_q[IDX_LANEB][15:12];
  assign turn_dis_a  = reg_q[IDX_LANEA][3:0];
  assign lane_en_a   = reg_q[IDX_LANEA][15:12];
  assign tp_clr      = reg_q[IDX_TPORT][0];
  assign tp_clk      = reg_q[IDX_TPORT][1];
  assign tp_en       = reg_q[IDX_TPORT][2];
  assign tp_din      = reg_q[IDX_TPORT][10:3];
  assign io_v18      = reg_q[IDX_IOCFG][1];
  assign clkout_drv  = reg_q[IDX_IOCFG][4:3];
  assign turn_req    = reg_q[IDX_TURN][3:0];
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic [35:0]       cfg_vec
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> $stable(cfg_vec)); // R1
  AST_NO_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_wdata[31:16] == 16'h0) |=> $stable(cfg_vec)); // R1
  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0); // R3
  AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(12'h2D4)) |=> ($stable(cfg_vec) && !bus_err)); // R9
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == 32'h0); // R10
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $stable(cfg_vec)); // R10
  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_err); // R10
endmodule

bind cfg_mask_regbank regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .cfg_vec   ({phy_in_sel, testbus_sel, lane_en_a, turn_dis_a, lane_en_b, turn_dis_b,
                turn_req, tp_clr, tp_clk, tp_en, tp_din, io_v18, clkout_drv})
);

// File: tb/cfg_mask_regbank_test.sv
module cfg_mask_regbank_test;
  localparam int PERIOD = 10;
  localparam int NR = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err;
  logic [7:0]  phy_test_dout;
  logic        phy_in_sel, testbus_sel, tp_clr, tp_clk, tp_en, io_v18;
  logic [3:0]  lane_en_a, turn_dis_a, lane_en_b, turn_dis_b, turn_req;
  logic [7:0]  tp_din;
  logic [1:0]  clkout_drv;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [NR];
  logic [11:0] ofs  [NR] = '{12'h25C, 12'h268, 12'h26C, 12'h27C, 12'h380, 12'h3A4};
  logic [15:0] impl [NR] = '{16'h4002, 16'hF00F, 16'hF00F, 16'h07FF, 16'h001A, 16'h000F};

  always #(PERIOD/2) clk = ~clk;

  cfg_mask_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .phy_test_dout(phy_test_dout), .phy_in_sel(phy_in_sel), .testbus_sel(testbus_sel),
    .lane_en_a(lane_en_a), .turn_dis_a(turn_dis_a), .lane_en_b(lane_en_b),
    .turn_dis_b(turn_dis_b), .turn_req(turn_req), .tp_clr(tp_clr), .tp_clk(tp_clk),
    .tp_en(tp_en), .tp_din(tp_din), .io_v18(io_v18), .clkout_drv(clkout_drv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic int idx_of(input logic [11:0] a);
    for (int i = 0; i < NR; i++) if (ofs[i] == a) return i;
    return -1;
  endfunction

  task automatic check_outs();
    chk("R4", {30'h0, phy_in_sel, testbus_sel}, {30'h0, model[0][1], model[0][14]});
    chk("R5", {24'h0, lane_en_b, turn_dis_b}, {24'h0, model[1][15:12], model[1][3:0]});
    chk("R5", {24'h0, lane_en_a, turn_dis_a}, {24'h0, model[2][15:12], model[2][3:0]});
    chk("R6", {21'h0, tp_din, tp_en, tp_clk, tp_clr}, {21'h0, model[3][10:0]});
    chk("R8", {29'h0, clkout_drv, io_v18}, {29'h0, model[4][4:3], model[4][1]});
    chk("R7", {28'h0, turn_req}, {28'h0, model[5][3:0]});
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic exp_err);
    int k;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    k = idx_of(a);
    if (k >= 0) begin
      logic [15:0] en;
      en = d[31:16] & impl[k];
      model[k] = (model[k] & ~en) | (d[15:0] & en);
    end
    chk("R10", {31'h0, bus_err}, {31'h0, exp_err});
    // R11: fields already visible in this cycle
    check_outs();
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic read_all(input string req);
    logic [31:0] rd;
    logic er;
    for (int i = 0; i < NR; i++) begin
      do_read(ofs[i], rd, er);
      chk(req, rd, {16'h0, model[i]});
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd, lf;
    logic er;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    phy_test_dout = 8'h00;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs();   // R2 reset state
    read_all("R2");

    // walking single bit set then clear, only that bit enabled
    for (int i = 0; i < NR; i++) begin
      for (int b = 0; b < 16; b++) begin
        do_write(ofs[i], (32'h1 << (b + 16)) | (32'h1 << b), 1'b0);
        do_read(ofs[i], rd, er);
        chk("R1", rd, {16'h0, model[i]});
      end
      for (int b = 0; b < 16; b++) begin
        do_write(ofs[i], 32'h1 << (b + 16), 1'b0);
        do_read(ofs[i], rd, er);
        chk("R3", rd, {16'h0, model[i]});
      end
    end

    // pseudo-random merge sequence
    lf = 32'h1234_5679;
    for (int n = 0; n < 400; n++) begin
      int k;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      k = int'(lf[7:0]) % NR;
      do_write(ofs[k], lf, 1'b0);
      do_read(ofs[k], rd, er);
      chk("R1", rd, {16'h0, model[k]});
      chk("R3", {31'h0, er}, 32'h0);
    end

    // data without enables leaves everything unchanged
    for (int i = 0; i < NR; i++) begin
      do_write(ofs[i], 32'h0000_FFFF, 1'b0);
      do_write(ofs[i], 32'h0000_0000, 1'b0);
    end
    read_all("R1");

    // status register
    for (int p = 0; p < 4; p++) begin
      phy_test_dout = (p == 0) ? 8'h00 : (p == 1) ? 8'hA5 : (p == 2) ? 8'h5A : 8'hFF;
      do_read(12'h2D4, rd, er);
      chk("R9", rd, {24'h0, phy_test_dout});
      chk("R9", {31'h0, er}, 32'h0);
    end
    do_write(12'h2D4, 32'hFFFF_FFFF, 1'b0);
    read_all("R9");

    // unmapped and misaligned addresses
    for (int u = 0; u < 6; u++) begin
      logic [11:0] ua;
      ua = (u == 0) ? 12'h000 : (u == 1) ? 12'h270 : (u == 2) ? 12'h27D :
           (u == 3) ? 12'h3A8 : (u == 4) ? 12'h25E : 12'hFFC;
      do_write(ua, 32'hFFFF_FFFF, 1'b1);
      do_read(ua, rd, er);
      chk("R10", rd, 32'h0);
      chk("R10", {31'h0, er}, 32'h1);
      @(negedge clk);
      chk("R10", {31'h0, bus_err}, 32'h0);
    end
    read_all("R10");

    // reset during operation
    do_write(ofs[3], 32'hFFFF_FFFF, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < NR; i++) model[i] = '0;
    check_outs();   // R2 asynchronous clear
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_all("R2");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule